// File: doc/BRIEF.md
# Lock-gated fuse key read controller

This block is a memory-mapped slave that lets software fetch words from a one-time-programmable fuse array, one word at a time. Software writes a single control word holding a byte index, an unlock byte and a read-request bit. If the unlock byte is exactly 0xAC, the block accepts the request. The request bit then serves as a busy flag. It stays at one while a fuse access of configurable latency runs, and it clears itself once the fetched word has been captured into a read-data register.

Writing zero to the control word clears the unlock byte and ends the access. If a read is still in progress, this write abandons it. The four words of the 128-bit root key can also be read directly through a fixed window, with no sequencing. The fuse array is a behavioural ROM filled from a parameter. The program path is only a stub: a holding register for program data, plus a program-start bit that never holds.

Top module: `fuse_key_reader`

## Requirements
- R1: After reset, the control word (offset 0x40), the read-data register (0x60) and the program-data register (0x50) all read zero.
- R2: A control write with bit 1 set and 0xAC in bits [15:8], made while idle, is accepted. Bit 1 of the control word then reads one, and the control word reads back the index (bits [24:16]) and the unlock byte that were written.
- R3: After an accepted request, bit 1 reads one for exactly LATENCY cycles, counted from the write edge. It then reads zero, and from that point the read-data register holds the new word.
- R4: The index field is a byte offset. Fuse word index[8:2] is returned, and index bits [1:0] are ignored.
- R5: An index whose word number index[8:2] is FUSE_WORDS or more returns zero data.
- R6: A request whose unlock byte is not 0xAC is ignored. Bit 1 reads zero, and the read-data register keeps its previous value.
- R7: While busy, any nonzero control write is ignored. The index, the busy flag and the eventual result are those of the original request.
- R8: A control write of zero while busy aborts the access. On the next cycle the control word reads zero and the read-data register keeps its previous value. A write of zero while idle also clears the control word.
- R9: Offset 0x200 + 4k, for k from 0 to 3, returns fuse word k directly, at any time.
- R10: The program-data register at 0x50 reads back the last value written to it. Bit 0 of the control word (program start) always reads zero.
- R11: A read from any offset that is not mapped returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte offset from the block base |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |

## Verification
The hardest states to reach from the ports are the ones where a control write lands inside the latency window. Two cases matter: a second valid-looking request that must be ignored, and a zero write that must abort the access without disturbing the read data. The bench reaches both by issuing a request and counting cycles before it writes again, so each write falls strictly between acceptance and capture. Random requests mix good and bad unlock bytes with indices across the whole 9-bit range, which covers out-of-range words and non-aligned offsets. The indexed results for words 0 to 3 are then compared against the direct window.

// File: rtl/fuse_key_reader.sv
module fuse_key_reader #(
  parameter int ADDR_W     = 12,
  parameter int FUSE_WORDS = 16,
  parameter int LATENCY    = 4,
  parameter logic [FUSE_WORDS*32-1:0] FUSE_IMAGE = {(FUSE_WORDS/2){64'h5A3C_96E1_0F1E_2D4B}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int IDX_W = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1;
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'('h040);
  localparam logic [ADDR_W-1:0] PGM_OFS  = ADDR_W'('h050);
  localparam logic [ADDR_W-1:0] KEY_OFS  = ADDR_W'('h060);
  localparam logic [ADDR_W-1:0] WIN_OFS  = ADDR_W'('h200);
  localparam logic [7:0]        UNLOCK   = 8'hAC;

  logic [31:0] rom [FUSE_WORDS];
  for (genvar i = 0; i < FUSE_WORDS; i++) begin : g_rom
    assign rom[i] = FUSE_IMAGE[i*32 +: 32];
  end

  logic [8:0]       idx_q;
  logic [7:0]       lock_q;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      key_q;
  logic [31:0]      pgm_q;

  wire        ctrl_wr  = wr_en && addr == CTRL_OFS;
  wire        start_ok = wdata[1] && wdata[15:8] == UNLOCK;
  wire [6:0]  word_sel = idx_q[8:2];
  wire        in_range = 32'(word_sel) < FUSE_WORDS;
  wire [31:0] fuse_val = in_range ? rom[word_sel[IDX_W-1:0]] : 32'h0;
  wire        in_win   = addr >= WIN_OFS && addr < WIN_OFS + ADDR_W'(16);
  wire        unused_bits = ^{wdata[31:25], wdata[7:2], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      lock_q <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
      key_q  <= '0;
    end else if (busy) begin
      if (ctrl_wr && wdata == 32'h0) begin
        idx_q  <= '0;
        lock_q <= '0;
        busy   <= 1'b0;
        cnt    <= '0;
      end else if (cnt == CNT_W'(1)) begin
        busy  <= 1'b0;
        cnt   <= '0;
        key_q <= fuse_val;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (ctrl_wr) begin
      idx_q  <= wdata[24:16];
      lock_q <= wdata[15:8];
      if (start_ok) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(LATENCY);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= '0;
    else if (wr_en && addr == PGM_OFS) pgm_q <= wdata;
  end

  always_comb begin
    rdata = 32'h0;
    if (addr == CTRL_OFS)     rdata = {7'h0, idx_q, lock_q, 6'h0, busy, 1'b0};
    else if (addr == PGM_OFS) rdata = pgm_q;
    else if (addr == KEY_OFS) rdata = key_q;
    else if (in_win)          rdata = rom[IDX_W'(addr[3:2])];
  end
endmodule

module fuse_key_reader_sva #(
  parameter int ADDR_W  = 12,
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              busy,
  input logic [31:0]       key_q
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'('h040);
  localparam int BW = $clog2(LATENCY + 2) + 1;
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  wire ctrl_wr = wr_en && addr == CTRL_OFS;

  a_r2_start_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl_wr && wdata[1] && wdata[15:8] == 8'hAC));
  a_r6_bad_lock_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrl_wr && wdata[15:8] != 8'hAC) |=> !busy);
  a_r8_zero_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && wdata == 32'h0) |=> (!busy && $stable(key_q)));
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= BW'(LATENCY));
  a_r3_data_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(key_q));
endmodule

bind fuse_key_reader fuse_key_reader_sva #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .key_q(key_q));

// File: tb/fuse_key_reader_test.sv
module fuse_key_reader_test;
  localparam int AW = 12;
  localparam int NW = 16;
  localparam int LAT = 6;

  function automatic logic [31:0] fw(int i);
    return 32'hC0DE_1000 ^ (32'(i) * 32'h0123_4567) ^ {24'h0, 8'(i)};
  endfunction
  function automatic logic [NW*32-1:0] build_img();
    logic [NW*32-1:0] v;
    for (int i = 0; i < NW; i++) v[i*32 +: 32] = fw(i);
    return v;
  endfunction
  function automatic logic [31:0] expect_word(logic [8:0] idx);
    int w = int'(idx[8:2]);
    return (w < NW) ? fw(w) : 32'h0;
  endfunction

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  logic [31:0] model_key = 0;

  fuse_key_reader #(.ADDR_W(AW), .FUSE_WORDS(NW), .LATENCY(LAT), .FUSE_IMAGE(build_img())) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask
  function automatic logic [31:0] req(logic [8:0] idx, logic [7:0] lock, logic go);
    return {7'h0, idx, lock, 6'h0, go, 1'b0};
  endfunction

  task automatic run_req(logic [8:0] idx, logic [7:0] lock, string tag);
    logic [31:0] v;
    int n = 0;
    wr(12'h040, req(idx, lock, 1'b1));
    rd(12'h040, v);
    while (v[1] && n < 100) begin n++; @(negedge clk); rd(12'h040, v); end
    if (lock == 8'hAC) begin
      check({tag, " R3 busy cycles"}, 32'(n), 32'(LAT));
      model_key = expect_word(idx);
    end else begin
      check({tag, " R6 busy never set"}, 32'(n), 32'h0);
    end
    rd(12'h060, v);
    check({tag, " R4/R5 read data"}, v, model_key);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] ind [4];
    void'($urandom(32'd1234));
    #12; rst_n = 1;
    @(negedge clk);
    rd(12'h040, v); check("R1 ctrl reset", v, 32'h0);
    rd(12'h060, v); check("R1 key reset", v, 32'h0);
    rd(12'h050, v); check("R1 pgm reset", v, 32'h0);

    wr(12'h040, req(9'd8, 8'hAC, 1'b1));
    rd(12'h040, v); check("R2 accepted readback", v, req(9'd8, 8'hAC, 1'b1));
    repeat (LAT) @(negedge clk);
    rd(12'h040, v); check("R3 busy cleared", v, req(9'd8, 8'hAC, 1'b0));
    rd(12'h060, v); check("R4 word 2", v, fw(2)); model_key = fw(2);

    run_req(9'd7, 8'hAC, "unaligned");
    run_req(9'd64, 8'hAC, "first out of range");
    run_req(9'd60, 8'hAC, "last word");
    run_req(9'd4, 8'hAB, "bad lock");
    run_req(9'd12, 8'h00, "zero lock");
    wr(12'h040, 32'h0);

    wr(12'h040, req(9'd0, 8'hAC, 1'b1));
    @(negedge clk);
    wr(12'h040, req(9'd20, 8'hAC, 1'b1));
    rd(12'h040, v); check("R7 write while busy ignored", v, req(9'd0, 8'hAC, 1'b1));
    repeat (LAT) @(negedge clk);
    rd(12'h060, v); check("R7 original result", v, fw(0)); model_key = fw(0);

    wr(12'h040, req(9'd36, 8'hAC, 1'b1));
    @(negedge clk);
    wr(12'h040, 32'h0);
    rd(12'h040, v); check("R8 abort clears ctrl", v, 32'h0);
    repeat (LAT + 2) @(negedge clk);
    rd(12'h060, v); check("R8 data kept after abort", v, fw(0));
    wr(12'h040, req(9'd3, 8'h11, 1'b0));
    wr(12'h040, 32'h0);
    rd(12'h040, v); check("R8 idle zero write", v, 32'h0);

    wr(12'h050, 32'hDEAD_BEEF);
    rd(12'h050, v); check("R10 pgm data", v, 32'hDEAD_BEEF);
    wr(12'h040, 32'h0000_AC01);
    rd(12'h040, v); check("R10 program bit reads zero", v[0], 1'b0);
    wr(12'h040, 32'h0);
    rd(12'h044, v); check("R11 unmapped", v, 32'h0);
    rd(12'h210, v); check("R11 past window", v, 32'h0);

    for (int i = 0; i < 40; i++) begin
      logic [8:0] idx = 9'($urandom_range(0, 511));
      logic [7:0] lk = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hAC;
      run_req(idx, lk, "random");
    end

    for (int k = 0; k < 4; k++) begin
      run_req(9'(k * 4), 8'hAC, "indexed key");
      rd(12'h060, ind[k]);
    end
    for (int k = 0; k < 4; k++) begin
      rd(12'(12'h200 + 4 * k), v);
      check("R9 window vs indexed", v, ind[k]);
      check("R9 window vs image", v, fw(k));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule